// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A synchronous single-port memory of 32-bit words with a registered read path. Every control input is sampled on the rising clock edge. An access begins on an edge where one of two address strobes is low, one from a processor and one from a controller. Read data passes through an output register, so it reaches the data-out port one clock after the address is taken. Writes can cover the whole word or only selected byte lanes. The shared data bus is split into a data-in port, a data-out port and a drive-enable flag. Whatever sits at the chip edge combines these three into one bus.

A strobe starts an access only when the chip is selected. The two strobes follow different rules. The processor strobe has priority and always opens an access with a read cycle. A write begun with that strobe completes on the following edge, using the write controls present on that edge. The controller strobe can write on its own edge. While an access is open and neither strobe is low, the advance input steps a two-bit wraparound burst counter. The counter is a separate sub-block, and a parameter selects either interleaved (XOR) or linear order for it.

Output drive is held off in three cases: after any write edge, after a deselecting edge, and for the first cycle of an access that starts from the deselected state. At other times the active-low output enable gates the drive without waiting for a clock edge.

Top module: `burst_sync_sram`

## Requirements
- R1: The output register loads on the edge after a read access edge. It loads the word at the address taken on that read edge. If neither a write nor a deselect happens on the loading edge, drive turns on after that edge, provided oe_n is low.
- R2: The chip counts as selected only when ce1_n is 0, ce2 is 1 and ce3_n is 0. A read begins on an edge where the chip is selected and gw_n and bwe_n are both 1, and where either of these holds: adsp_n is 0, or adsc_n is 0 while adsp_n is 1. A strobe that is low while the chip is not selected is a deselect.
- R3: adsp_n has no effect while ce1_n is 1. When both strobes are low and the chip is selected, the processor strobe wins, so the edge is a read and no write takes place.
- R4: An edge started by adsp_n never writes. On that edge the write controls and adv_n are ignored. If the next edge is a continuation (both strobes high) with a write combination, it writes using the controls sampled on that next edge.
- R5: An edge with adsc_n at 0, adsp_n at 1, the chip selected and a write combination writes in that same cycle. adv_n is ignored on that edge.
- R6: A write combination is gw_n at 0 or bwe_n at 0. gw_n at 0 writes all four byte lanes, whatever bwe_n and bw_sel are. Otherwise, with bwe_n at 0, lane i (data bits 8i+7..8i) is written only when bw_sel[i] is 1. Lanes that are not written keep their contents.
- R7: dq_oe is never 1 while oe_n is 1. dq_oe stays 0 during the cycle after an edge that opens an access from the deselected state.
- R8: After any edge on which a write takes place, dq_oe is 0 for the following cycle.
- R9: After a deselect edge, dq_oe is 0 and the access is closed. Later continuation cycles then neither read nor write.
- R10: On a continuation edge with adv_n at 0, the two low address bits step the burst. With INTERLEAVE=1 the sequence is start XOR n. With INTERLEAVE=0 it is (start+n) mod 4. The upper address bits stay fixed, and both reads and writes on that edge use the stepped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address taken when a strobe starts an access |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip select 1, active low; also gates adsp_n |
| ce2 | input | 1 | Chip select 2, active high |
| ce3_n | input | 1 | Chip select 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_sel | input | LANES | Byte lane selects, active high |
| oe_n | input | 1 | Output enable, active low, not clocked |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Drive enable for dq_out |

## Verification
The bench builds two copies with ADDR_W=6, one with INTERLEAVE=1 and one with INTERLEAVE=0, and drives both with the same stimulus. A 64-word array is small enough to fill completely at the start, so every later read has a known expected word. Starting bursts at low address bits 01 separates the two orders (01,00,11,10 against 01,10,11,00) and makes both of them wrap. Burst writes made through the advance input land on different words in the two copies, and read-back bursts then confirm those words.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;

  // Decoded view of one clock edge's control inputs.
  typedef struct packed {
    logic p_start;
    logic c_start;
    logic desel;
    logic cont;
    logic wr_intent;
  } edge_dec_t;

  // Low two address bits of a burst, 'step' beats after the first one.
  function automatic logic [1:0] burst_low(input logic [1:0] first,
                                           input logic [1:0] step,
                                           input logic       xor_order);
    logic [1:0] r;
    if (xor_order) r = first ^ step;
    else           r = first + step;
    return r;
  endfunction

  function automatic logic chip_on(input logic c1_n, input logic c2, input logic c3_n);
    return !c1_n && c2 && !c3_n;
  endfunction

endpackage

// File: rtl/bsram_burst_ctr.sv
`timescale 1ns/1ps
module bsram_burst_ctr
  import bsram_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] next_addr
);
  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic [1:0]        step_nx;
  logic [1:0]        cur_lo;
  logic [1:0]        nxt_lo;

  assign step_nx = step_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
    end else if (load) begin
      base_q <= load_addr;
      step_q <= '0;
    end else if (adv) begin
      step_q <= step_nx;
    end
  end

  if (INTERLEAVE) begin : g_xor_order
    assign cur_lo = burst_low(base_q[1:0], step_q,  1'b1);
    assign nxt_lo = burst_low(base_q[1:0], step_nx, 1'b1);
  end else begin : g_lin_order
    assign cur_lo = burst_low(base_q[1:0], step_q,  1'b0);
    assign nxt_lo = burst_low(base_q[1:0], step_nx, 1'b0);
  end

  assign cur_addr  = {base_q[ADDR_W-1:2], cur_lo};
  assign next_addr = {base_q[ADDR_W-1:2], nxt_lo};

  // R10: each advance moves the low bits and never touches the upper bits
  assert_adv_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (cur_addr[1:0] != $past(cur_addr[1:0])));
  assert_adv_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/bsram_access_ctl.sv
`timescale 1ns/1ps
module bsram_access_ctl
  import bsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_sel,
  output logic             ctr_load,
  output logic             ctr_adv,
  output logic             wr_en,
  output logic [LANES-1:0] wr_mask,
  output logic             rd_fire,
  output logic             drv_q,
  output logic             open_q
);

  function automatic logic [LANES-1:0] lane_mask(input logic g_n, input logic b_n,
                                                 input logic [LANES-1:0] sel);
    logic [LANES-1:0] m;
    if (!g_n)      m = '1;
    else if (!b_n) m = sel;
    else           m = '0;
    return m;
  endfunction

  edge_dec_t dec;
  logic      on;
  logic      rd_start;
  logic      rd_pend_q;

  // Named edge events, brought out for the checks below
  assign on            = chip_on(ce1_n, ce2, ce3_n);
  assign dec.p_start   = !adsp_n && on;
  assign dec.c_start   = !adsc_n && adsp_n && on;
  assign dec.desel     = (!adsc_n || (!adsp_n && !ce1_n)) && !on;
  assign dec.cont      = open_q && !dec.p_start && !dec.c_start && !dec.desel;
  assign dec.wr_intent = !gw_n || !bwe_n;

  assign wr_en    = (dec.c_start || dec.cont) && dec.wr_intent;
  assign wr_mask  = lane_mask(gw_n, bwe_n, bw_sel);
  assign rd_start = dec.p_start || ((dec.c_start || dec.cont) && !dec.wr_intent);
  assign ctr_load = dec.p_start || dec.c_start;
  assign ctr_adv  = dec.cont && !adv_n;
  assign rd_fire  = rd_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      rd_pend_q <= 1'b0;
      drv_q     <= 1'b0;
    end else begin
      if (ctr_load)       open_q <= 1'b1;
      else if (dec.desel) open_q <= 1'b0;
      rd_pend_q <= rd_start;
      drv_q     <= rd_pend_q && !dec.desel && !wr_en;
    end
  end

  // R1: a pending read whose loading edge is clean turns drive on
  assert_read_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend_q && !wr_en && !dec.desel) |=> drv_q);
  // R4: processor-started write lands on the next continuation edge
  assert_pwrite_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dec.p_start) && dec.cont && !gw_n) |-> (wr_en && (&wr_mask)));
  // R5: controller write completes on its own edge without advancing
  assert_cwrite_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && adsp_n && on && !gw_n) |-> (wr_en && ctr_load && !ctr_adv));
  // R6: without a global write only selected lanes are written
  assert_lane_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && gw_n) |-> ((wr_mask & ~bw_sel) == '0));
  // R7: first cycle of an access opened from deselect is quiet
  assert_first_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && ctr_load) |=> !drv_q);
  // R8: a write edge blanks the drive
  assert_write_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !drv_q);
  // R9: deselect closes the access and blanks the drive
  assert_desel_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec.desel |=> (!drv_q && !open_q));
endmodule

// File: rtl/bsram_array.sv
`timescale 1ns/1ps
module bsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] out_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[i]) cells[wr_addr] <= wr_data[LANE_W*i +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     out_q <= '0;
      else if (rd_en) out_q <= cells[rd_addr];
    end

    assign rd_data[LANE_W*i +: LANE_W] = out_q;
  end
endmodule

// File: rtl/burst_sync_sram.sv
`timescale 1ns/1ps
module burst_sync_sram #(
  parameter int ADDR_W     = 8,
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_sel,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  logic              ctr_load, ctr_adv, wr_en, rd_fire, drv_q, open_q;
  logic [LANES-1:0]  wr_mask;
  logic [ADDR_W-1:0] cur_addr, next_addr, acc_addr;

  bsram_access_ctl #(.LANES(LANES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_sel(bw_sel), .ctr_load(ctr_load), .ctr_adv(ctr_adv), .wr_en(wr_en),
    .wr_mask(wr_mask), .rd_fire(rd_fire), .drv_q(drv_q), .open_q(open_q)
  );

  bsram_burst_ctr #(.ADDR_W(ADDR_W), .INTERLEAVE(INTERLEAVE)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .adv(ctr_adv),
    .load_addr(addr), .cur_addr(cur_addr), .next_addr(next_addr)
  );

  // Address of the access taking place on this edge
  assign acc_addr = ctr_load ? addr : (ctr_adv ? next_addr : cur_addr);

  bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(acc_addr),
    .wr_mask(wr_mask), .wr_data(dq_in), .rd_en(rd_fire),
    .rd_addr(cur_addr), .rd_data(dq_out)
  );

  assign dq_oe = drv_q && !oe_n;

  // R7: output enable gates the drive at all times
  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !oe_n);
  // R9: a closed access never drives in the cycle after closing
  assert_closed_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !ctr_load) |=> !drv_q);
endmodule

// File: tb/sim_burst_sync_sram.sv
`timescale 1ns/1ps
module sim_burst_sync_sram;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] addr = '0;
  logic adsp_n = 1, adsc_n = 1, adv_n = 1, ce1_n = 1, ce2 = 0, ce3_n = 1;
  logic gw_n = 1, bwe_n = 1, oe_n = 1;
  logic [3:0]  bw_sel = '0;
  logic [31:0] dq_in = '0;
  logic [31:0] out0, out1;
  logic        oe0, oe1;

  burst_sync_sram #(.ADDR_W(AW), .INTERLEAVE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_sel(bw_sel), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(out0), .dq_oe(oe0));

  burst_sync_sram #(.ADDR_W(AW), .INTERLEAVE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_sel(bw_sel), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(out1), .dq_oe(oe1));

  typedef struct {
    bit          oe;
    logic [31:0] d0;
    logic [31:0] d1;
    string       tag;
  } exp_t;
  exp_t q[$];

  int  n_run = 0, n_fail = 0;
  bit  done = 0;

  // Reference state, kept from the requirements
  logic [31:0] mem0 [64];
  logic [31:0] mem1 [64];
  bit          m_open = 0, m_rd = 0;
  logic [AW-1:0] m_base = '0;
  int          m_beats = 0;

  // Word address of the current beat; xor_order picks the burst order
  function automatic logic [AW-1:0] beat_addr(bit xor_order);
    logic [1:0] lo;
    lo = m_base[1:0];
    for (int k = 0; k < m_beats % 4; k++)
      lo = xor_order ? (m_base[1:0] ^ 2'(k + 1)) : 2'((lo + 2'd1) & 2'b11);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic cyc(input bit p, input bit c, input bit v, input bit e1, input bit e2,
                     input bit e3, input bit g, input bit b, input bit [3:0] s,
                     input bit o, input int a, input logic [31:0] d, input string tag);
    bit on, ps, cs, ds, ct, wi, we;
    exp_t e;
    @(negedge clk);
    adsp_n = p; adsc_n = c; adv_n = v; ce1_n = e1; ce2 = e2; ce3_n = e3;
    gw_n = g; bwe_n = b; bw_sel = s; oe_n = o; addr = AW'(a); dq_in = d;
    on = (e1 == 0) && (e2 == 1) && (e3 == 0);
    ps = !p && on;
    cs = !c && p && on;
    ds = (!c || (!p && !e1)) && !on;
    ct = m_open && !ps && !cs && !ds;
    wi = !g || !b;
    we = (cs || ct) && wi;
    e.d0 = mem0[beat_addr(1)];
    e.d1 = mem1[beat_addr(0)];
    e.oe = m_rd && !ds && !we && !o;
    e.tag = tag;
    if (ps || cs) begin m_base = AW'(a); m_beats = 0; end
    else if (ct && !v) m_beats++;
    if (we) begin
      for (int i = 0; i < 4; i++) begin
        if (!g || (!b && s[i])) begin
          mem0[beat_addr(1)][8*i +: 8] = d[8*i +: 8];
          mem1[beat_addr(0)][8*i +: 8] = d[8*i +: 8];
        end
      end
    end
    m_rd = ps || ((cs || ct) && !wi);
    if (ps || cs) m_open = 1; else if (ds) m_open = 0;
    q.push_back(e);
  endtask

  task automatic idle(input bit o, input string tag);
    cyc(1, 1, 1, 0, 1, 0, 1, 1, 4'h0, o, 0, 32'h0, tag);
  endtask
  task automatic cwr(input int a, input logic [31:0] d, input bit g, input bit b,
                     input bit [3:0] s, input string tag);
    cyc(1, 0, 1, 0, 1, 0, g, b, s, 0, a, d, tag);
  endtask
  task automatic prd(input int a, input bit v, input string tag);
    cyc(0, 1, v, 0, 1, 0, 1, 1, 4'h0, 0, a, 32'h0, tag);
  endtask
  task automatic crd(input int a, input string tag);
    cyc(1, 0, 1, 0, 1, 0, 1, 1, 4'h0, 0, a, 32'h0, tag);
  endtask
  task automatic step(input bit g, input bit b, input bit [3:0] s, input logic [31:0] d,
                      input string tag);
    cyc(1, 1, 0, 0, 1, 0, g, b, s, 0, 0, d, tag);
  endtask
  task automatic dsl(input string tag);
    cyc(1, 0, 1, 1, 1, 0, 1, 1, 4'h0, 0, 0, 32'h0, tag);
  endtask

  // Monitor: compares each expected item after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (oe0 !== e.oe || oe1 !== e.oe) begin
          n_fail++;
          $display("FAIL %s drive: actual=%b/%b expected=%b", e.tag, oe0, oe1, e.oe);
        end else if (e.oe && (out0 !== e.d0 || out1 !== e.d1)) begin
          n_fail++;
          $display("FAIL %s data: actual=%h/%h expected=%h/%h", e.tag, out0, out1, e.d0, e.d1);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    n_run++;
    if (oe0 !== 1'b0 || oe1 !== 1'b0 || out0 !== 32'h0) begin
      n_fail++;
      $display("FAIL R1 reset: actual=%b/%h expected=0/00000000", oe0, out0);
    end
    @(negedge clk) rst_n = 1;

    // R5/R6: fill the whole array with global controller writes
    for (int i = 0; i < 64; i++)
      cwr(i, 32'hA5000000 ^ (i * 32'h00010307), 0, 1, 4'h0, "R5");

    dsl("R9");
    prd(5, 1, "R7");           // first cycle from deselect stays quiet
    idle(0, "R1");             // word 5 appears
    idle(0, "R1");             // continuation re-reads word 5
    idle(1, "R7");             // oe_n high blocks drive
    crd(9, "R2");              // back-to-back read
    idle(0, "R2");
    cwr(9, 32'h11223344, 1, 0, 4'b0101, "R8");   // byte write blanks drive
    crd(9, "R6");
    idle(0, "R6");             // lanes 0 and 2 merged

    // R4: processor write, controls and adv_n ignored on first edge
    cyc(0, 1, 0, 0, 1, 0, 0, 1, 4'h0, 0, 12, 32'hDEADBEEF, "R4");
    cyc(1, 1, 1, 0, 1, 0, 1, 0, 4'b1000, 0, 0, 32'h77665544, "R4");
    crd(12, "R4");
    idle(0, "R4");

    // R3: both strobes low with write controls: processor wins, no write
    cyc(0, 0, 1, 0, 1, 0, 0, 1, 4'h0, 0, 20, 32'hFFFFFFFF, "R3");
    idle(0, "R3");
    // R3: adsp_n low while ce1_n high is ignored; access keeps reading
    cyc(0, 1, 1, 1, 1, 0, 1, 1, 4'h0, 0, 30, 32'h0, "R3");
    idle(0, "R3");
    // R2/R9: ce2 low with a strobe deselects
    cyc(1, 0, 1, 0, 0, 0, 1, 1, 4'h0, 0, 7, 32'h0, "R9");
    idle(0, "R9");             // closed: nothing driven
    // bwe_n low with no lanes selected: write edge, word unchanged
    crd(40, "R2");
    cyc(1, 1, 1, 0, 1, 0, 1, 0, 4'h0, 0, 0, 32'h0, "R8");
    crd(40, "R6");
    idle(0, "R6");

    // R10: burst read from low bits 01, both orders, with wrap
    dsl("R9");
    prd(5, 0, "R10");          // adv_n low ignored on start edge
    for (int k = 0; k < 4; k++) step(1, 1, 4'h0, 32'h0, "R10");
    idle(0, "R10");

    // R10: burst write via advance, then read back
    cwr(17, 32'h0BAD0001, 0, 1, 4'h0, "R5");
    step(0, 1, 4'h0, 32'h0BAD0002, "R10");
    step(0, 1, 4'h0, 32'h0BAD0003, "R10");
    step(1, 0, 4'b0011, 32'h0BAD0004, "R10");
    prd(16, 1, "R10");
    for (int k = 0; k < 4; k++) step(1, 1, 4'h0, 32'h0, "R10");
    idle(0, "R10");
    dsl("R9");
    idle(0, "R9");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule